// File: doc/BRIEF.md
# Synchronous Burst Static Memory Controller

This block is the control and address path of a flow-through synchronous burst static memory, with a small internal array so that it can be checked end to end. Each access starts on a rising clock edge. The external address is captured when one of two address strobes is low and all three chip selects are active. After that, the block generates the following addresses of a four-beat burst by itself, one step for each edge on which the step strobe is low.

The two strobes have different priority. The processor-side strobe always starts a read. The controller-side strobe starts a read or a write, depending on the write enable. Between loads, the step strobe either moves to the next beat or holds the current address (suspend). The write enable chooses on each of these edges whether the held or stepped location is read or written.

Burst order is picked per edge by a mode input: interleaved when it is high, linear when it is low. Read data comes from the address register through the array, with no output register. The output drive is gated asynchronously by an active-low output enable. The full-size part uses a 17-bit word address; the default here is smaller so that it suits simulation.

Top module: `sbs_top`

## Requirements
- R1: A synchronous active-high reset ends any access. Afterwards `rdata_oe` is 0 and `rdata` is all zeros until a new read starts.
- R2: A load edge is one where either strobe is low. It starts an access only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. Otherwise the block deselects: it drives no output, and it writes nothing until the next enabled load.
- R3: `cpu_strb_n`=0 on an enabled edge loads `ext_addr` and starts a read. This happens whatever `ctl_strb_n`, `wr_n` and `step_n` are on that edge.
- R4: `ctl_strb_n`=0 with `cpu_strb_n`=1 on an enabled edge loads `ext_addr`. If `wr_n`=0, that edge writes `wdata` to the loaded address. If `wr_n`=1, it starts a read.
- R5: On an edge with both strobes high during an access and `step_n`=0, the beat count advances modulo 4. Only address bits [1:0] change; the upper bits stay as loaded.
- R6: With `order_ilv`=1, address bits [1:0] equal the start offset XOR the beat count. With `order_ilv`=0, they equal (start offset + beat count) mod 4. The mode is sampled on every edge.
- R7: On an edge with both strobes high and `step_n`=1 during an access, the address is held (suspend). On every edge with both strobes high during an access, `wr_n`=0 writes `wdata` to that edge's address and `wr_n`=1 reads it.
- R8: Reads are flow-through. The word at the address registered on an edge appears on `rdata` in that same clock cycle, before the next edge.
- R9: `rdata_oe` is 1 exactly when a read is active and `out_en_n`=0. A change of `out_en_n` takes effect without a clock edge. While `rdata_oe` is 0, `rdata` is all zeros.
- R10: On a write, lane i covers bits [i*DATA_W/4 +: DATA_W/4] (9 bits per lane at the 36-bit default). A lane is written only when `lane_wr_n[i]`=0; the other lanes keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ext_addr | input | ADDR_W (8) | External word address |
| cpu_strb_n | input | 1 | Processor-side address strobe, active low, highest priority |
| ctl_strb_n | input | 1 | Controller-side address strobe, active low |
| step_n | input | 1 | Burst step strobe, active low |
| wr_n | input | 1 | Write enable, active low |
| lane_wr_n | input | LANES (4) | Per-lane write enables, active low |
| sel_a_n | input | 1 | Chip select A, active low |
| sel_b | input | 1 | Chip select B, active high |
| sel_c_n | input | 1 | Chip select C, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| order_ilv | input | 1 | Burst order: 1 interleaved, 0 linear |
| wdata | input | DATA_W (36) | Write data |
| rdata | output | DATA_W (36) | Read data, zero when not driven |
| rdata_oe | output | 1 | Read data drive enable |

## Verification
The assertions assume that the strobes, the chip selects and the write enable are stable around each rising edge, and that strobe activity before the first enabled load does not matter. The bench keeps to this: it changes every input only at the falling edge, and it starts every sequence with an enabled load. The hold and step properties also assume that `ext_addr` has no effect on edges where both strobes are high. The stimulus therefore drives an unrelated address on those edges. Only `out_en_n` is changed between edges, because it is the one input defined to act without the clock.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int BEAT_W = 2;

  typedef logic [BEAT_W-1:0] beat_t;

  // Offset of a burst beat inside its four-word group.
  function automatic beat_t beat_offset(input beat_t start, input beat_t beat,
                                        input logic ilv);
    return ilv ? (start ^ beat) : beat_t'(start + beat);
  endfunction
endpackage

// File: rtl/sbs_ctl.sv
module sbs_ctl
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              cpu_strb_n,
  input  logic              ctl_strb_n,
  input  logic              step_n,
  input  logic              wr_n,
  input  logic              chip_ok,
  input  logic              order_ilv,
  output logic [ADDR_W-1:0] addr_q,
  output logic [ADDR_W-1:0] addr_nxt,
  output logic              wr_go,
  output logic              rd_q,
  output logic              act_q
);
  localparam int HI_W = ADDR_W - BEAT_W;

  logic [HI_W-1:0] base_q, base_n;
  beat_t           start_q, start_n, cnt_q, cnt_n;
  logic            act_n, rd_n;
  logic            load_cpu, load_ctl, cont;

  assign load_cpu = !cpu_strb_n;
  assign load_ctl = cpu_strb_n && !ctl_strb_n;
  assign cont     = cpu_strb_n && ctl_strb_n && act_q;

  always_comb begin
    base_n  = base_q;
    start_n = start_q;
    cnt_n   = cnt_q;
    act_n   = act_q;
    rd_n    = rd_q;
    wr_go   = 1'b0;
    if (load_cpu || load_ctl) begin
      if (chip_ok) begin
        base_n  = ext_addr[ADDR_W-1:BEAT_W];
        start_n = ext_addr[BEAT_W-1:0];
        cnt_n   = '0;
        act_n   = 1'b1;
        rd_n    = load_cpu || wr_n;
        wr_go   = load_ctl && !wr_n;
      end else begin
        act_n = 1'b0;
        rd_n  = 1'b0;
      end
    end else if (cont) begin
      if (!step_n) cnt_n = cnt_q + 1'b1;
      rd_n  = wr_n;
      wr_go = !wr_n;
    end
    addr_nxt = {base_n, beat_offset(start_n, cnt_n, order_ilv)};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      start_q <= '0;
      cnt_q   <= '0;
      act_q   <= 1'b0;
      rd_q    <= 1'b0;
      addr_q  <= '0;
    end else begin
      base_q  <= base_n;
      start_q <= start_n;
      cnt_q   <= cnt_n;
      act_q   <= act_n;
      rd_q    <= rd_n;
      addr_q  <= addr_nxt;
    end
  end

  // R3: processor-side load reads the external address
  assert_cpu_load_R3: assert property (@(posedge clk) disable iff (rst)
    (!cpu_strb_n && chip_ok) |=> (act_q && rd_q && addr_q == $past(ext_addr)));

  // R2: a load without all chip selects deselects
  assert_deselect_R2: assert property (@(posedge clk) disable iff (rst)
    ((!cpu_strb_n || !ctl_strb_n) && !chip_ok) |=> !act_q);

  // R4: controller-side load with write enable low is a write
  assert_ctl_write_R4: assert property (@(posedge clk) disable iff (rst)
    (cpu_strb_n && !ctl_strb_n && chip_ok && !wr_n) |=>
      (act_q && !rd_q && addr_q == $past(ext_addr)));

  // R7: suspend holds the address
  assert_suspend_R7: assert property (@(posedge clk) disable iff (rst)
    (act_q && cpu_strb_n && ctl_strb_n && step_n) |=> $stable(addr_q));

  // R5: a step moves only inside the four-word group
  assert_step_R5: assert property (@(posedge clk) disable iff (rst)
    (act_q && cpu_strb_n && ctl_strb_n && !step_n) |=>
      (addr_q[ADDR_W-1:BEAT_W] == $past(addr_q[ADDR_W-1:BEAT_W]) &&
       addr_q != $past(addr_q)));
endmodule

// File: rtl/sbs_store.sv
module sbs_store #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 36,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [LANES-1:0]  wr_lanes,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rdata
);
  localparam int LW    = DATA_W / LANES;
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && wr_lanes[g]) mem[wr_addr] <= wdata[g*LW +: LW];
    end

    assign rdata[g*LW +: LW] = mem[rd_addr];
  end
endmodule

// File: rtl/sbs_top.sv
module sbs_top #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 36,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              cpu_strb_n,
  input  logic              ctl_strb_n,
  input  logic              step_n,
  input  logic              wr_n,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              out_en_n,
  input  logic              order_ilv,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe
);
  logic [ADDR_W-1:0] addr_q, addr_nxt;
  logic              wr_go, rd_q, act_q, chip_ok;
  logic [DATA_W-1:0] arr_rd;

  assign chip_ok = !sel_a_n && sel_b && !sel_c_n;

  sbs_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk(clk), .rst(rst), .ext_addr(ext_addr),
    .cpu_strb_n(cpu_strb_n), .ctl_strb_n(ctl_strb_n), .step_n(step_n),
    .wr_n(wr_n), .chip_ok(chip_ok), .order_ilv(order_ilv),
    .addr_q(addr_q), .addr_nxt(addr_nxt), .wr_go(wr_go),
    .rd_q(rd_q), .act_q(act_q)
  );

  sbs_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_store (
    .clk(clk), .wr_en(wr_go), .wr_lanes(~lane_wr_n), .wr_addr(addr_nxt),
    .wdata(wdata), .rd_addr(addr_q), .rdata(arr_rd)
  );

  // Flow-through read path; output enable gates the drive without a clock.
  assign rdata_oe = act_q && rd_q && !out_en_n;
  assign rdata    = rdata_oe ? arr_rd : '0;
endmodule

// File: tb/sbs_top_tb.sv
`timescale 1ns/100ps
module sbs_top_tb;
  localparam int AW = 8;
  localparam int DW = 36;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] ext_addr = '0;
  logic          cpu_strb_n = 1'b1, ctl_strb_n = 1'b1, step_n = 1'b1, wr_n = 1'b1;
  logic [3:0]    lane_wr_n = 4'h0;
  logic          sel_a_n = 1'b0, sel_b = 1'b1, sel_c_n = 1'b0;
  logic          out_en_n = 1'b0, order_ilv = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          rdata_oe;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  sbs_top #(.ADDR_W(AW), .DATA_W(DW), .LANES(4)) u_dut (
    .clk(clk), .rst(rst), .ext_addr(ext_addr), .cpu_strb_n(cpu_strb_n),
    .ctl_strb_n(ctl_strb_n), .step_n(step_n), .wr_n(wr_n),
    .lane_wr_n(lane_wr_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .sel_c_n(sel_c_n), .out_en_n(out_en_n), .order_ilv(order_ilv),
    .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  function automatic logic [DW-1:0] pat(input logic [7:0] t);
    return {4{1'b0, t}};
  endfunction

  // Row: cpu, ctl, step, wr, ilv, addr, tag, expected drive, expected tag
  function automatic logic [29:0] v(input logic c, input logic k, input logic s,
      input logic w, input logic i, input logic [7:0] a, input logic [7:0] t,
      input logic d, input logic [7:0] e);
    return {c, k, s, w, i, a, t, d, e};
  endfunction

  localparam int NV = 17;
  localparam logic [29:0] VEC [NV] = '{
    v(1,0,1,0,0,8'h10,8'hA0,0,8'h00),  // R4 write at load
    v(1,1,0,0,0,8'h00,8'hA1,0,8'h00),  // R5 R7 stepped writes, linear
    v(1,1,0,0,0,8'h00,8'hA2,0,8'h00),
    v(1,1,0,0,0,8'h00,8'hA3,0,8'h00),
    v(1,1,0,0,0,8'h00,8'hA4,0,8'h00),  // R5 wrap to offset 0
    v(0,0,0,0,0,8'h12,8'h00,1,8'hA2),  // R3 read despite ctl/wr/step low
    v(1,1,0,1,0,8'h00,8'h00,1,8'hA3),  // R6 linear 2+1
    v(1,1,0,1,0,8'h00,8'h00,1,8'hA4),  // R6 linear 2+2 wraps
    v(1,1,1,1,0,8'h00,8'h00,1,8'hA4),  // R7 suspend
    v(1,1,0,1,0,8'h00,8'h00,1,8'hA1),  // R6 linear 2+3
    v(0,1,1,1,1,8'h11,8'h00,1,8'hA1),  // R3 R8 interleaved start 1
    v(1,1,0,1,1,8'h00,8'h00,1,8'hA4),  // R6 1^1
    v(1,1,0,1,1,8'h00,8'h00,1,8'hA3),  // R6 1^2
    v(1,1,0,1,1,8'h00,8'h00,1,8'hA2),  // R6 1^3
    v(1,0,1,1,0,8'h13,8'h00,1,8'hA3),  // R4 controller read
    v(1,1,1,0,0,8'h00,8'hB3,0,8'h00),  // R7 write on suspend edge
    v(1,1,1,1,0,8'h00,8'h00,1,8'hB3)   // R7 R8 read back
  };

  task automatic chk(input string req, input logic [DW-1:0] got,
                     input logic [DW-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic drive(input logic c, input logic k, input logic s,
      input logic w, input logic i, input logic [7:0] a, input logic [DW-1:0] d);
    cpu_strb_n = c; ctl_strb_n = k; step_n = s; wr_n = w;
    order_ilv = i; ext_addr = a; wdata = d;
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tick;
    rst = 1'b0;
    chk("R1 reset drive", {35'd0, rdata_oe}, '0);
    chk("R1 reset data", rdata, '0);

    // Table walk: sampled at the falling edge after each rising edge (R8).
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][29], VEC[i][28], VEC[i][27], VEC[i][26], VEC[i][25],
            VEC[i][24:17], pat(VEC[i][16:9]));
      tick;
      chk("R3 R4 R5 R6 R7 R8 drive", {35'd0, rdata_oe}, {35'd0, VEC[i][8]});
      chk("R3 R4 R5 R6 R7 R8 data", rdata,
          VEC[i][8] ? pat(VEC[i][7:0]) : '0);
    end

    // R2: controller write with a chip select inactive is dropped.
    sel_b = 1'b0;
    drive(1, 0, 1, 0, 0, 8'h12, pat(8'hEE));
    tick;
    chk("R2 deselect drive", {35'd0, rdata_oe}, '0);
    sel_b = 1'b1;
    drive(1, 1, 1, 0, 0, 8'h12, pat(8'hEF));
    tick;
    chk("R2 idle write drive", {35'd0, rdata_oe}, '0);
    drive(0, 1, 1, 1, 0, 8'h12, '0);
    tick;
    chk("R2 location kept", rdata, pat(8'hA2));

    // R9: output enable acts between edges.
    #0.5 out_en_n = 1'b1;
    #0.5;
    chk("R9 oe off drive", {35'd0, rdata_oe}, '0);
    chk("R9 oe off data", rdata, '0);
    out_en_n = 1'b0;
    #0.5;
    chk("R9 oe on data", rdata, pat(8'hA2));
    @(negedge clk);

    // R10: lane-gated write.
    drive(1, 0, 1, 0, 0, 8'h20, pat(8'h11));
    tick;
    lane_wr_n = 4'b1010;
    drive(1, 0, 1, 0, 0, 8'h20, pat(8'h22));
    tick;
    lane_wr_n = 4'h0;
    drive(0, 1, 1, 1, 0, 8'h20, '0);
    tick;
    chk("R10 lanes", rdata,
        {1'b0, 8'h11, 1'b0, 8'h22, 1'b0, 8'h11, 1'b0, 8'h22});

    // R1: reset in the middle of a read burst.
    drive(1, 1, 0, 1, 0, 8'h00, '0);
    rst = 1'b1;
    tick;
    chk("R1 mid-burst reset drive", {35'd0, rdata_oe}, '0);
    rst = 1'b0;
    tick;
    chk("R1 stays idle", {35'd0, rdata_oe}, '0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule